// File: doc/BRIEF.md
# Low-Power Sleep Entry/Exit Controller

This block decides when the processor core leaves a low-power run state for a low-power sleep state, and when it comes back. It watches three single-cycle requests from the core: wait-for-interrupt, wait-for-event, and return-from-handler. It also watches three control levels: a deep-sleep select, a sleep-after-handler bit and a pending-wakes-event bit. Its other inputs are the pending and enabled interrupt vectors and a wake-up event line. Its outputs are the current mode, a gate enable for the core clock, and a code that records how sleep was entered.

The block has two states. `MODE_RUN` (encoded 0) is low-power run and `MODE_SLEEP` (encoded 1) is sleep. There are three entry transitions, one per request kind, and each has its own blocking condition. There is a single exit transition. Which wake sources count for the exit depends on the entry code held while asleep. A one-bit event register remembers a wake-up event seen outside an event-wait sleep, so that a later event-wait returns at once instead of sleeping. The clock gate opens combinationally in the cycle the wake condition appears. The mode and the entry code update at the following edge.

Top module: `lps_sleep_ctrl`

## Requirements
- R1: After reset the mode is run (0), the core clock enable is 1 and the entry code is none (2'b00).
- R2: In run with deep-sleep select 0, a wait-for-interrupt request with no enabled pending interrupt (no bit set in pending AND enabled) moves the mode to sleep at the next edge with entry code 2'b01. With an enabled pending interrupt, the request is dropped.
- R3: In run with deep-sleep select 0, a wait-for-event request moves the mode to sleep with entry code 2'b10 when no event is stored and the wake-up event line is low.
- R4: In run with deep-sleep select 0, a return-from-handler request enters sleep with entry code 2'b11 only when sleep-after-handler is 1 and no enabled interrupt is pending. Otherwise it is dropped.
- R5: While deep-sleep select is 1, every request is dropped. The mode stays run, and nothing is retried later.
- R6: Asleep with code 2'b01 or 2'b11, only a pending interrupt that is also enabled wakes the core. A disabled pending interrupt or a wake-up event leaves it asleep.
- R7: Asleep with code 2'b10 and pending-wakes-event 0, only the wake-up event line wakes the core. Enabled pending interrupts do not.
- R8: Asleep with code 2'b10 and pending-wakes-event 1, either the wake-up event line or any pending interrupt wakes the core, even one that is disabled.
- R9: The clock enable is 0 only in sleep, and it goes to 1 in the same cycle the wake condition holds. At the next edge the mode returns to run and the entry code clears to 2'b00.
- R10: Requests that arrive while asleep are ignored.
- R11: A wake-up event seen while not in an event-wait sleep is stored. The next wait-for-event request consumes it and stays in run. The same applies when the event line is high in the cycle of that request. A wait-for-event request after that enters sleep.
- R12: When several requests arrive in the same cycle, only the highest one is considered: wait-for-interrupt, then wait-for-event, then return-from-handler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wfi_req | input | 1 | Wait-for-interrupt request strobe |
| wfe_req | input | 1 | Wait-for-event request strobe |
| isr_ret | input | 1 | Return-from-handler strobe |
| deep_sel | input | 1 | Deep-sleep select; 1 blocks all entry |
| sleep_on_exit | input | 1 | Permit sleep on return from handler |
| sev_on_pend | input | 1 | Let any pending interrupt wake an event-wait sleep |
| irq_pend | input | NIRQ | Pending interrupt vector |
| irq_en | input | NIRQ | Enabled interrupt vector |
| wake_evt | input | 1 | Wake-up event line |
| mode_o | output | 1 | Current mode: 0 run, 1 sleep |
| core_clk_en | output | 1 | Core clock gate enable |
| entry_kind | output | 2 | Entry code: 00 none, 01 interrupt-wait, 10 event-wait, 11 after-handler |

## Verification
The hardest case to reach is the stored-event path. The event register can only be loaded while the core is running or in a sleep that is not an event-wait, and its effect shows only as a later wait-for-event that does not sleep. The stimulus gets there by raising the wake-up event line during an interrupt-wait sleep, which must not wake the core. It then waits for an interrupt-driven exit and issues a wait-for-event. The mode is expected to stay in run for that request, and the next wait-for-event is expected to sleep. A second pass drives the event line high in the same cycle as the wait-for-event request and expects the same result.

// File: rtl/lps_pkg.sv
package lps_pkg;

    typedef enum logic {
        MODE_RUN   = 1'b0,
        MODE_SLEEP = 1'b1
    } lp_mode_t;

    typedef enum logic [1:0] {
        ENT_NONE = 2'b00,
        ENT_WFI  = 2'b01,
        ENT_WFE  = 2'b10,
        ENT_EXIT = 2'b11
    } ent_kind_t;

endpackage

// File: rtl/lps_entry_arb.sv
module lps_entry_arb
    import lps_pkg::*;
(
    input  logic      in_run,
    input  logic      wfi_req,
    input  logic      wfe_req,
    input  logic      isr_ret,
    input  logic      deep_sel,
    input  logic      sleep_on_exit,
    input  logic      irq_hit,
    input  logic      evt_pend,
    output logic      go_sleep,
    output ent_kind_t go_kind,
    output logic      wfe_consume
);

    always_comb begin
        go_sleep    = 1'b0;
        go_kind     = ENT_NONE;
        wfe_consume = 1'b0;
        if (in_run && !deep_sel) begin
            if (wfi_req) begin
                if (!irq_hit) begin
                    go_sleep = 1'b1;
                    go_kind  = ENT_WFI;
                end
            end else if (wfe_req) begin
                if (evt_pend) begin
                    wfe_consume = 1'b1;
                end else begin
                    go_sleep = 1'b1;
                    go_kind  = ENT_WFE;
                end
            end else if (isr_ret) begin
                if (sleep_on_exit && !irq_hit) begin
                    go_sleep = 1'b1;
                    go_kind  = ENT_EXIT;
                end
            end
        end
    end

    // R12: a single kind is chosen per cycle
    always_comb begin
        if (go_sleep) begin
            a_kind_valid_r12: assert (go_kind != ENT_NONE);
        end
    end

endmodule

// File: rtl/lps_wake_eval.sv
module lps_wake_eval
    import lps_pkg::*;
#(
    parameter int NIRQ = 8
) (
    input  logic            asleep,
    input  ent_kind_t       kind,
    input  logic            sev_on_pend,
    input  logic [NIRQ-1:0] irq_pend,
    input  logic [NIRQ-1:0] irq_en,
    input  logic            wake_evt,
    output logic            irq_hit,
    output logic            wake
);

    logic any_pend;

    assign irq_hit  = |(irq_pend & irq_en);
    assign any_pend = |irq_pend;

    always_comb begin
        wake = 1'b0;
        if (asleep) begin
            unique case (kind)
                ENT_WFI, ENT_EXIT: wake = irq_hit;
                ENT_WFE:           wake = wake_evt | (sev_on_pend & any_pend);
                ENT_NONE:          wake = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/lps_event_latch.sv
module lps_event_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_evt,
    input  logic consume,
    input  logic absorb,
    output logic evt_pend
);

    logic evt_q;

    assign evt_pend = evt_q | wake_evt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= 1'b0;
        end else if (consume || absorb) begin
            evt_q <= 1'b0;
        end else begin
            evt_q <= evt_pend;
        end
    end

endmodule

// File: rtl/lps_sleep_ctrl.sv
module lps_sleep_ctrl
    import lps_pkg::*;
#(
    parameter int NIRQ = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wfi_req,
    input  logic            wfe_req,
    input  logic            isr_ret,
    input  logic            deep_sel,
    input  logic            sleep_on_exit,
    input  logic            sev_on_pend,
    input  logic [NIRQ-1:0] irq_pend,
    input  logic [NIRQ-1:0] irq_en,
    input  logic            wake_evt,
    output logic            mode_o,
    output logic            core_clk_en,
    output logic [1:0]      entry_kind
);

    lp_mode_t  state_q, state_d;
    ent_kind_t kind_q,  kind_d;
    logic      go_sleep, wfe_consume, wake, irq_hit, evt_pend;
    ent_kind_t go_kind;
    logic      asleep;

    assign asleep = (state_q == MODE_SLEEP);

    lps_wake_eval #(.NIRQ(NIRQ)) u_wake (
        .asleep      (asleep),
        .kind        (kind_q),
        .sev_on_pend (sev_on_pend),
        .irq_pend    (irq_pend),
        .irq_en      (irq_en),
        .wake_evt    (wake_evt),
        .irq_hit     (irq_hit),
        .wake        (wake)
    );

    lps_entry_arb u_arb (
        .in_run        (!asleep),
        .wfi_req       (wfi_req),
        .wfe_req       (wfe_req),
        .isr_ret       (isr_ret),
        .deep_sel      (deep_sel),
        .sleep_on_exit (sleep_on_exit),
        .irq_hit       (irq_hit),
        .evt_pend      (evt_pend),
        .go_sleep      (go_sleep),
        .go_kind       (go_kind),
        .wfe_consume   (wfe_consume)
    );

    lps_event_latch u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .wake_evt (wake_evt),
        .consume  (wfe_consume),
        .absorb   (asleep && (kind_q == ENT_WFE)),
        .evt_pend (evt_pend)
    );

    // next-state: entry and exit transitions
    always_comb begin
        state_d = state_q;
        kind_d  = kind_q;
        unique case (state_q)
            MODE_RUN: begin
                if (go_sleep) begin
                    state_d = MODE_SLEEP;
                    kind_d  = go_kind;
                end
            end
            MODE_SLEEP: begin
                if (wake) begin
                    state_d = MODE_RUN;
                    kind_d  = ENT_NONE;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MODE_RUN;
            kind_q  <= ENT_NONE;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
        end
    end

    // outputs
    always_comb begin
        mode_o      = state_q;
        entry_kind  = kind_q;
        core_clk_en = !asleep || wake;
    end

    p_gate_open_in_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_RUN) |-> core_clk_en);

    p_exit_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_SLEEP && core_clk_en) |=> (mode_o == MODE_RUN && entry_kind == 2'b00));

    p_deep_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_RUN && deep_sel) |=> (mode_o == MODE_RUN));

    p_wfe_no_irq_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_SLEEP && entry_kind == 2'b10 && !sev_on_pend && !wake_evt) |-> !core_clk_en);

    p_irq_wakes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_SLEEP && entry_kind != 2'b10 && |(irq_pend & irq_en)) |-> core_clk_en);

    p_sleep_has_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_SLEEP) |-> (entry_kind != 2'b00));

    p_hold_asleep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_SLEEP && !core_clk_en) |=> (mode_o == MODE_SLEEP && $stable(entry_kind)));

endmodule

// File: tb/sim_lps_sleep_ctrl.sv
module sim_lps_sleep_ctrl;

    localparam int NIRQ = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wfi_req = 0, wfe_req = 0, isr_ret = 0;
    logic            deep_sel = 0, sleep_on_exit = 0, sev_on_pend = 0;
    logic [NIRQ-1:0] irq_pend = '0, irq_en = '0;
    logic            wake_evt = 0;
    logic            mode_o, core_clk_en;
    logic [1:0]      entry_kind;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic       em;
        logic       ec;
        logic [1:0] ek;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    lps_sleep_ctrl #(.NIRQ(NIRQ)) u0 (
        .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .wfe_req(wfe_req),
        .isr_ret(isr_ret), .deep_sel(deep_sel), .sleep_on_exit(sleep_on_exit),
        .sev_on_pend(sev_on_pend), .irq_pend(irq_pend), .irq_en(irq_en),
        .wake_evt(wake_evt), .mode_o(mode_o), .core_clk_en(core_clk_en),
        .entry_kind(entry_kind)
    );

    // driver: apply one cycle of stimulus and queue what must be seen in it
    task automatic step(input logic [2:0] strb, input logic ds, input logic soe,
                        input logic sev, input logic [7:0] pend, input logic [7:0] en,
                        input logic evt, input logic em, input logic ec,
                        input logic [1:0] ek, input string tag);
        exp_t e;
        @(negedge clk);
        wfi_req = strb[2]; wfe_req = strb[1]; isr_ret = strb[0];
        deep_sel = ds; sleep_on_exit = soe; sev_on_pend = sev;
        irq_pend = pend; irq_en = en; wake_evt = evt;
        e.em = em; e.ec = ec; e.ek = ek; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input logic em, input logic ec, input logic [1:0] ek, input string tag);
        step(3'b000, 0, 0, 0, 8'h00, 8'h00, 0, em, ec, ek, tag);
    endtask

    // monitor: compare between edges
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (mode_o !== e.em || core_clk_en !== e.ec || entry_kind !== e.ek) begin
                    errors++;
                    $display("FAIL %s: got mode=%b clk_en=%b kind=%b, expected mode=%b clk_en=%b kind=%b",
                             e.tag, mode_o, core_clk_en, entry_kind, e.em, e.ec, e.ek);
                end
            end
        end
    end

    initial begin
        for (int c = 0; c < 5000; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(0, 1, 2'b00, "R1 reset state");

        // R2 interrupt-wait entry, R6 wake rules
        step(3'b100, 0, 0, 0, 8'h00, 8'h00, 0, 0, 1, 2'b00, "R2 wfi strobe");
        idle(1, 0, 2'b01, "R2 asleep kind 01");
        step(3'b000, 0, 0, 0, 8'h00, 8'hFF, 0, 1, 0, 2'b01, "R6 enabled no pend");
        step(3'b000, 0, 0, 0, 8'h01, 8'h00, 0, 1, 0, 2'b01, "R6 disabled pend");
        step(3'b000, 0, 0, 0, 8'h00, 8'h00, 1, 1, 0, 2'b01, "R6 event ignored");
        step(3'b000, 0, 0, 0, 8'h04, 8'h04, 0, 1, 1, 2'b01, "R9 same-cycle wake");
        idle(0, 1, 2'b00, "R9 back to run");

        // R11 stored event consumed
        step(3'b010, 0, 0, 0, 8'h00, 8'h00, 0, 0, 1, 2'b00, "R11 wfe strobe");
        idle(0, 1, 2'b00, "R11 stayed in run");
        step(3'b010, 0, 0, 0, 8'h00, 8'h00, 0, 0, 1, 2'b00, "R3 wfe strobe");
        idle(1, 0, 2'b10, "R3 asleep kind 10");
        step(3'b000, 0, 0, 0, 8'h01, 8'h01, 0, 1, 0, 2'b10, "R7 irq no wake");
        step(3'b100, 0, 0, 0, 8'h00, 8'h00, 0, 1, 0, 2'b10, "R10 wfi ignored");
        step(3'b000, 0, 0, 0, 8'h00, 8'h00, 1, 1, 1, 2'b10, "R7 event wakes");
        idle(0, 1, 2'b00, "R9 exit clears kind");

        // R8 pending-wakes-event
        step(3'b010, 0, 0, 1, 8'h00, 8'h00, 0, 0, 1, 2'b00, "R8 wfe strobe");
        step(3'b000, 0, 0, 1, 8'h00, 8'h00, 0, 1, 0, 2'b10, "R8 asleep");
        step(3'b000, 0, 0, 1, 8'h02, 8'h00, 0, 1, 1, 2'b10, "R8 disabled irq wakes");
        idle(0, 1, 2'b00, "R8 back to run");

        // R4 after-handler entry
        step(3'b001, 0, 1, 0, 8'h00, 8'h00, 0, 0, 1, 2'b00, "R4 ret strobe");
        idle(1, 0, 2'b11, "R4 asleep kind 11");
        step(3'b000, 0, 0, 0, 8'h00, 8'h00, 1, 1, 0, 2'b11, "R6 event no wake exit-kind");
        step(3'b000, 0, 0, 0, 8'h80, 8'h80, 0, 1, 1, 2'b11, "R6 irq wakes exit-kind");
        idle(0, 1, 2'b00, "R4 back to run");
        // stored event from the sleep above: drain it
        step(3'b010, 0, 0, 0, 8'h00, 8'h00, 0, 0, 1, 2'b00, "R11 drain strobe");
        idle(0, 1, 2'b00, "R11 drained, run");
        step(3'b001, 0, 0, 0, 8'h00, 8'h00, 0, 0, 1, 2'b00, "R4 ret soe=0");
        idle(0, 1, 2'b00, "R4 ret soe=0 stays run");
        step(3'b001, 0, 1, 0, 8'h01, 8'h01, 0, 0, 1, 2'b00, "R4 ret with pend");
        idle(0, 1, 2'b00, "R4 ret with pend stays run");

        // R5 deep-sleep blocks, no retry
        step(3'b100, 1, 0, 0, 8'h00, 8'h00, 0, 0, 1, 2'b00, "R5 wfi deep");
        idle(0, 1, 2'b00, "R5 wfi dropped");
        step(3'b010, 1, 0, 0, 8'h00, 8'h00, 0, 0, 1, 2'b00, "R5 wfe deep");
        idle(0, 1, 2'b00, "R5 wfe dropped");
        step(3'b001, 1, 1, 0, 8'h00, 8'h00, 0, 0, 1, 2'b00, "R5 ret deep");
        idle(0, 1, 2'b00, "R5 ret dropped");

        // R2 blocking and disabled pending
        step(3'b100, 0, 0, 0, 8'h10, 8'h10, 0, 0, 1, 2'b00, "R2 wfi blocked");
        idle(0, 1, 2'b00, "R2 blocked stays run");
        step(3'b100, 0, 0, 0, 8'h10, 8'h00, 0, 0, 1, 2'b00, "R2 wfi disabled pend");
        step(3'b000, 0, 0, 0, 8'h10, 8'h00, 0, 1, 0, 2'b01, "R2 asleep despite disabled");
        step(3'b000, 0, 0, 0, 8'h10, 8'h10, 0, 1, 1, 2'b01, "R6 enable wakes");
        idle(0, 1, 2'b00, "R6 run");

        // R12 priority
        step(3'b111, 0, 1, 0, 8'h00, 8'h00, 0, 0, 1, 2'b00, "R12 all strobes");
        idle(1, 0, 2'b01, "R12 wfi wins");
        step(3'b000, 0, 0, 0, 8'h01, 8'h01, 0, 1, 1, 2'b01, "R12 wake");
        idle(0, 1, 2'b00, "R12 run");
        step(3'b011, 0, 1, 0, 8'h00, 8'h00, 0, 0, 1, 2'b00, "R12 wfe+ret");
        idle(1, 0, 2'b10, "R12 wfe wins");
        step(3'b000, 0, 0, 0, 8'h00, 8'h00, 1, 1, 1, 2'b10, "R12 wake");
        idle(0, 1, 2'b00, "R12 run again");

        // R11 event in same cycle as request
        step(3'b010, 0, 0, 0, 8'h00, 8'h00, 1, 0, 1, 2'b00, "R11 wfe with evt");
        idle(0, 1, 2'b00, "R11 same-cycle consumed");
        step(3'b010, 0, 0, 0, 8'h00, 8'h00, 0, 0, 1, 2'b00, "R11 wfe again");
        idle(1, 0, 2'b10, "R11 now sleeps");
        step(3'b000, 0, 0, 0, 8'h00, 8'h00, 1, 1, 1, 2'b10, "R7 wake");
        idle(0, 1, 2'b00, "R9 final run");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule